// File: doc/BRIEF.md
# Parallel Port Extended Control Register Block

This block is the host-facing register set of a PC-style parallel port with extended transfer modes. It decodes a byte-wide I/O read/write bus and holds four registers: a data byte, a read-only printer status byte, a printer control byte and an extended control byte at a separate offset. The extended control byte selects the operating mode, gates DMA requests, carries a hardware-set interrupt pending flag, and reports FIFO full and empty from an external FIFO level count. The transfer handshakes, the FIFO storage and the DMA engine live elsewhere. This block supplies the mode code, the gated DMA request and the interrupt pulse to those neighbours.

The fault interrupt is handled by a four-state machine. ARMED is the reset state: the disable bit is 0 and nothing is pending. MASKED means the disable bit is 1. PULSE drives `irq` for exactly one clock. HELD means the pending flag is set. The transitions are as follows. ARMED goes to MASKED on a write that sets the disable bit. ARMED goes to PULSE on a synchronised falling edge of `prn_err_n`. MASKED goes to PULSE on a write that clears the disable bit while the synchronised fault level is low. MASKED goes to ARMED on a write that clears the disable bit while the fault level is high. PULSE always goes to HELD. HELD goes to MASKED or ARMED, by the written disable bit, on an extended control write that has bit 2 at 0.

Top module: `lpt_ext_ctrl`

## Requirements
- R1: After reset the data byte, the control bits and the extended control bits 7..2 are all 0, `irq` is 0, `mode_sel` is 000 and `dma_req_out` is 0.
- R2: Offset 0 is a read/write data byte driven on `lpt_data`. Offset 2 stores bits 4..0 (bit 4 interrupt enable, 3 select, 2 initialise active low, 1 auto line feed, 0 strobe), which drive `lpt_ctl`. Its bits 7..5 read as 0. `io_rdata` is 0 when `io_rd` is 0.
- R3: Offset 1 reads {`prn_busy_n`, `prn_ack_n`, `prn_pe`, `prn_slct`, `prn_err_n`, 1, 1, 1} from bit 7 down to bit 0. A write to offset 1 changes nothing that can be observed.
- R4: Extended control bits 7..5 store and read back any written mode code. `mode_sel` equals that code (000 standard, 001 byte-wide bidirectional, 010 FIFO, 011 extended capability, 100 enhanced, 111 configuration), except that the reserved codes 101 and 110 give 000.
- R5: Extended control bit 1 reads 1 exactly when `fifo_level` is at least FIFO_DEPTH (16). Bit 0 reads 1 exactly when `fifo_level` is 0. Writes to these bits are ignored.
- R6: In ARMED, when `prn_err_n` is first sampled low at clock edge k after being high, `irq` is 1 for the single cycle that follows edge k+2.
- R7: In MASKED, an extended control write with bit 4 at 0, made while `prn_err_n` has been low for at least two edges, makes `irq` 1 in the cycle after that write's edge.
- R8: While extended control bit 4 is 1, falling edges of `prn_err_n` produce no `irq`.
- R9: An `irq` pulse sets bit 2, and bit 2 reads 1 from the pulse cycle onward. While bit 2 is 1, fault edges raise no `irq` and `dma_req_out` is 0. An extended control write with bit 2 at 0 clears it. Software cannot set it, and a write during the pulse cycle does not clear it.
- R10: `dma_req_out` is 1 exactly when `dma_req_in` is 1, extended control bit 3 is 1 and bit 2 is 0.
- R11: `irq` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 11 | Register offset from the port base |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read enable |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| prn_busy_n | input | 1 | Printer busy, active low |
| prn_ack_n | input | 1 | Acknowledge, active low |
| prn_pe | input | 1 | Paper empty |
| prn_slct | input | 1 | Printer online |
| prn_err_n | input | 1 | Printer error / fault, active low, asynchronous |
| fifo_level | input | 5 | Bytes held in the external FIFO |
| dma_req_in | input | 1 | Raw DMA request from the transfer logic |
| dma_req_out | output | 1 | Gated DMA request |
| lpt_data | output | 8 | Data register contents |
| lpt_ctl | output | 5 | Control register bits 4..0 |
| mode_sel | output | 3 | Decoded operating mode |
| irq | output | 1 | One-cycle fault interrupt pulse |

## Verification
The interrupt logic is driven with an isolated fault falling edge, with edges that arrive while interrupts are masked, and with edges that arrive while an interrupt is pending. It is also driven with a clear of the disable bit while the fault is held low. Between them, these patterns separate edge-triggered firing from level-triggered firing, and they show that the pending flag gates both interrupt paths. The disable bit is cleared once with the fault high and once with it low, which separates the two exits from MASKED. DMA gating is tried across all combinations of request, enable and pending. Mode codes are walked through all eight values so that the two reserved codes are distinguished from the real ones.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [2:0] {
        MODE_STD  = 3'b000,
        MODE_BIDI = 3'b001,
        MODE_FIFO = 3'b010,
        MODE_XCAP = 3'b011,
        MODE_ENH  = 3'b100,
        MODE_CFG  = 3'b111
    } lpt_mode_e;

    typedef enum logic [1:0] {
        IRQ_ARMED  = 2'd0,
        IRQ_MASKED = 2'd1,
        IRQ_PULSE  = 2'd2,
        IRQ_HELD   = 2'd3
    } irq_state_e;

    // Reserved codes fall back to standard mode
    function automatic lpt_mode_e decode_mode(input logic [2:0] code);
        lpt_mode_e m;
        unique case (code)
            3'b001:  m = MODE_BIDI;
            3'b010:  m = MODE_FIFO;
            3'b011:  m = MODE_XCAP;
            3'b100:  m = MODE_ENH;
            3'b111:  m = MODE_CFG;
            default: m = MODE_STD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lpt_fault_sync.sv
module lpt_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level_n,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_n = chain_q[STAGES-1];
    assign fall    = prev_q & ~chain_q[STAGES-1];

    // R6: a single input transition yields a single edge indication
    p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/lpt_irq_fsm.sv
module lpt_irq_fsm
    import lpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ecr_wr,
    input  logic wr_dis,
    input  logic wr_pend,
    input  logic dis_q,
    input  logic fault_lvl_n,
    input  logic fault_fall,
    output logic irq,
    output logic pending
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_ARMED: begin
                if (ecr_wr && wr_dis)  state_d = IRQ_MASKED;
                else if (fault_fall)   state_d = IRQ_PULSE;
            end
            IRQ_MASKED: begin
                if (ecr_wr && !wr_dis)
                    state_d = fault_lvl_n ? IRQ_ARMED : IRQ_PULSE;
            end
            IRQ_PULSE: state_d = IRQ_HELD;
            IRQ_HELD: begin
                if (ecr_wr && !wr_pend)
                    state_d = wr_dis ? IRQ_MASKED : IRQ_ARMED;
            end
            default: state_d = IRQ_ARMED;
        endcase
    end

    always_comb begin
        irq     = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            IRQ_PULSE: begin irq = 1'b1; pending = 1'b1; end
            IRQ_HELD:  pending = 1'b1;
            default:   ;
        endcase
    end

    // R11: pulse lasts one clock
    p_irq_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: no pulse while the stored disable bit is set
    p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !dis_q);
    // R9: pending stays until a clearing write
    p_held_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(ecr_wr && !wr_pend)) |=> pending);

endmodule

// File: rtl/lpt_ecr.sv
module lpt_ecr
    import lpt_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:3]       wdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             pending,
    output logic [2:0]       mode_sel,
    output logic             dis_q,
    output logic             dma_en,
    output logic [7:0]       rdata
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic [2:0] mode_q;
    logic       fifo_full, fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'b000;
            dis_q  <= 1'b0;
            dma_en <= 1'b0;
        end else if (wr) begin
            mode_q <= wdata[7:5];
            dis_q  <= wdata[4];
            dma_en <= wdata[3];
        end
    end

    assign fifo_full  = (fifo_level >= FULL_LVL);
    assign fifo_empty = (fifo_level == '0);
    assign mode_sel   = decode_mode(mode_q);
    assign rdata      = {mode_q, dis_q, dma_en, pending, fifo_full, fifo_empty};

endmodule

// File: rtl/lpt_ext_ctrl.sv
module lpt_ext_ctrl
    import lpt_pkg::*;
#(
    parameter int              ADDR_W     = 11,
    parameter int              FIFO_DEPTH = 16,
    parameter int              SYNC_STG   = 2,
    parameter logic [10:0]     ECR_OFS    = 11'h400,
    localparam int             LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              prn_busy_n,
    input  logic              prn_ack_n,
    input  logic              prn_pe,
    input  logic              prn_slct,
    input  logic              prn_err_n,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              dma_req_in,
    output logic              dma_req_out,
    output logic [7:0]        lpt_data,
    output logic [4:0]        lpt_ctl,
    output logic [2:0]        mode_sel,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_ECR  = ADDR_W'(ECR_OFS);

    logic       wr_data, wr_ctrl, wr_ecr;
    logic       dis_q, dma_en, pending;
    logic       fault_lvl_n, fault_fall;
    logic [7:0] ecr_rdata, stat_rdata;

    assign wr_data = io_wr && (io_addr == OFS_DATA);
    assign wr_ctrl = io_wr && (io_addr == OFS_CTRL);
    assign wr_ecr  = io_wr && (io_addr == OFS_ECR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lpt_data <= 8'h00;
            lpt_ctl  <= 5'h00;
        end else begin
            if (wr_data) lpt_data <= io_wdata;
            if (wr_ctrl) lpt_ctl  <= io_wdata[4:0];
        end
    end

    lpt_fault_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (prn_err_n),
        .level_n (fault_lvl_n),
        .fall    (fault_fall)
    );

    lpt_ecr #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_ecr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_ecr),
        .wdata      (io_wdata[7:3]),
        .fifo_level (fifo_level),
        .pending    (pending),
        .mode_sel   (mode_sel),
        .dis_q      (dis_q),
        .dma_en     (dma_en),
        .rdata      (ecr_rdata)
    );

    lpt_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ecr_wr      (wr_ecr),
        .wr_dis      (io_wdata[4]),
        .wr_pend     (io_wdata[2]),
        .dis_q       (dis_q),
        .fault_lvl_n (fault_lvl_n),
        .fault_fall  (fault_fall),
        .irq         (irq),
        .pending     (pending)
    );

    assign dma_req_out = dma_req_in & dma_en & ~pending;
    assign stat_rdata  = {prn_busy_n, prn_ack_n, prn_pe, prn_slct, prn_err_n, 3'b111};

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd) begin
            if (io_addr == OFS_DATA)      io_rdata = lpt_data;
            else if (io_addr == OFS_STAT) io_rdata = stat_rdata;
            else if (io_addr == OFS_CTRL) io_rdata = {3'b000, lpt_ctl};
            else if (io_addr == OFS_ECR)  io_rdata = ecr_rdata;
        end
    end

    // R4: reserved codes never reach the mode output
    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_sel == 3'b101 || mode_sel == 3'b110));

endmodule

// File: tb/sim_lpt_ext_ctrl.sv
module sim_lpt_ext_ctrl;
    localparam int ECR = 11'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        busy_n = 1'b1, ack_n = 1'b1, pe = 1'b0, slct = 1'b1, err_n = 1'b1;
    logic [4:0]  fifo_level = '0;
    logic        dma_in = 1'b0, dma_out;
    logic [7:0]  lpt_data;
    logic [4:0]  lpt_ctl;
    logic [2:0]  mode_sel;
    logic        irq;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    lpt_ext_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .prn_busy_n(busy_n),
        .prn_ack_n(ack_n), .prn_pe(pe), .prn_slct(slct), .prn_err_n(err_n),
        .fifo_level(fifo_level), .dma_req_in(dma_in), .dma_req_out(dma_out),
        .lpt_data(lpt_data), .lpt_ctl(lpt_ctl), .mode_sel(mode_sel), .irq(irq)
    );

    // Behavioural reference model
    int m_data, m_ctl, m_mode, m_dis, m_dma, m_pend, m_irq;
    int f1, f2, fprev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 0; m_ctl = 0; m_mode = 0; m_dis = 0; m_dma = 0;
            m_pend = 0; m_irq = 0; f1 = 1; f2 = 1; fprev = 1;
        end else begin
            bit we, fire, fall;
            int nd;
            we = io_wr && io_addr == ECR;
            fall = (fprev == 1) && (f2 == 0);
            nd = we ? int'(io_wdata[4]) : m_dis;
            fire = 0;
            if (m_irq) m_irq = 0;
            else if (m_pend) begin
                if (we && !io_wdata[2]) m_pend = 0;
            end else if (m_dis) begin
                if (we && !io_wdata[4] && f2 == 0) fire = 1;
            end else if (nd == 0 && fall) fire = 1;
            if (fire) begin m_irq = 1; m_pend = 1; end
            m_dis = nd;
            if (we) begin m_mode = io_wdata[7:5]; m_dma = io_wdata[3]; end
            if (io_wr && io_addr == 0) m_data = io_wdata;
            if (io_wr && io_addr == 2) m_ctl = io_wdata[4:0];
            fprev = f2; f2 = f1; f1 = err_n;
        end
    end

    function automatic int exp_rdata();
        if (!io_rd) return 0;
        case (io_addr)
            0: return m_data;
            1: return {busy_n, ack_n, pe, slct, err_n, 3'b111};
            2: return m_ctl;
            ECR: return (m_mode << 5) | (m_dis << 4) | (m_dma << 3) | (m_pend << 2)
                        | ((fifo_level >= 16) << 1) | (fifo_level == 0);
            default: return 0;
        endcase
    endfunction

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int md;
            md = (m_mode == 5 || m_mode == 6) ? 0 : m_mode;
            chk("irq (R6/R11)", irq, m_irq);
            chk("dma_req_out (R10)", dma_out, dma_in && m_dma && !m_pend);
            chk("mode_sel (R4)", mode_sel, md);
            chk("lpt_data (R2)", lpt_data, m_data);
            chk("lpt_ctl (R2)", lpt_ctl, m_ctl);
            chk("io_rdata", io_rdata, exp_rdata());
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(int a, int d);
        io_addr = 11'(a); io_wdata = 8'(d); io_wr = 1'b1;
        step(); io_wr = 1'b0;
    endtask

    task automatic rd(int a);
        io_addr = 11'(a); io_rd = 1'b1;
        step(); io_rd = 1'b0;
    endtask

    task automatic fault(bit v, int hold);
        err_n = v; step(hold);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3); rst_n = 1'b1; step();
        tag = "R1";
        rd(0); rd(2); rd(ECR);
        chk("irq after reset R1", irq, 0);

        tag = "R2";
        wr(0, 8'hA5); rd(0); wr(0, 8'h3C); rd(0);
        wr(2, 8'hFF); rd(2); wr(2, 8'h0A); rd(2);

        tag = "R3";
        busy_n = 0; ack_n = 1; pe = 1; slct = 0; step(); rd(1);
        busy_n = 1; ack_n = 0; pe = 0; slct = 1; step(); rd(1);
        wr(1, 8'h00); rd(1); rd(0); rd(2);

        tag = "R4";
        for (int m = 0; m < 8; m++) begin wr(ECR, m << 5); rd(ECR); end
        wr(ECR, 8'h00);

        tag = "R5";
        fifo_level = 0; rd(ECR);
        fifo_level = 7; rd(ECR);
        fifo_level = 16; rd(ECR);
        wr(ECR, 8'h03); fifo_level = 5; rd(ECR);

        tag = "R6";
        fault(0, 6); rd(ECR);
        fault(1, 4);
        wr(ECR, 8'h00); rd(ECR);
        fault(0, 1); fault(1, 1); fault(0, 6);
        wr(ECR, 8'h00); fault(1, 4);

        tag = "R8";
        wr(ECR, 8'h10);
        fault(0, 5); fault(1, 4); fault(0, 5);
        rd(ECR);

        tag = "R7";
        wr(ECR, 8'h00); step(3); rd(ECR);
        wr(ECR, 8'h10); fault(1, 4);
        wr(ECR, 8'h00); step(3); rd(ECR);

        tag = "R9";
        wr(ECR, 8'h08); dma_in = 1; fault(0, 6); rd(ECR);
        fault(1, 3); fault(0, 6);
        wr(ECR, 8'h0C); rd(ECR);
        wr(ECR, 8'h08); rd(ECR);
        fault(1, 3);
        io_addr = 11'(ECR); io_wdata = 8'h08;
        err_n = 0; step(2); io_wr = 1'b1; step(); io_wr = 1'b0;
        rd(ECR); step(2);
        wr(ECR, 8'h08); rd(ECR);

        tag = "R10";
        dma_in = 0; step(); dma_in = 1; step();
        wr(ECR, 8'h00); step(); dma_in = 0; step();
        wr(ECR, 8'h08); dma_in = 1; step(2);

        tag = "R11";
        fault(1, 3); fault(0, 8); wr(ECR, 8'h08); step(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule